// File: doc/BRIEF.md
# USB Remote Wakeup Sequencer

This block moves a full-speed USB device controller from suspend back to active operation. It has two independent paths. On the device side, firmware sets a wake request level. The block then waits for the bus to stay in the idle (J) state for an unbroken interval. It then drives a K state on the line for a fixed resume period and finally raises a sticky done interrupt. The block never clears the request itself: firmware drops it after it sees the interrupt.

On the host side, firmware can stop a gated oscillator through a power-down control. When host wake is enabled, a falling edge on D+ restarts the oscillator. The block then counts a stabilisation interval and reports readiness with a level and a sticky interrupt. Every interval is counted in pulses of a 12 MHz tick that arrives on the block clock, so 5 ms is 60000 ticks.

Top module: `usb_wake_seq`

## Requirements
- R1: After reset the resume drive is off, both line-drive outputs are 0, the oscillator is enabled and reported stable, and both interrupt flags are 0.
- R2: Once `wake_req` is seen high, the resume drive turns on at the clock edge that completes IDLE_TICKS consecutive edges on which `tick_12m` is 1 and the line is J (`line_dp`=1, `line_dm`=0). An edge whose tick is 0 neither counts nor restarts.
- R3: During that wait, any edge that samples a non-J line (SE0 00, K 01, SE1 11 on D+,D-) restarts the idle count from zero.
- R4: While the resume drive is on, the outputs carry K (`drv_dp`=0, `drv_dm`=1). They are 0,0 otherwise. The drive lasts exactly RESUME_TICKS tick edges.
- R5: The edge that ends the drive sets `rwu_done_irq`. While `wake_req` stays high afterwards, no new wait or drive starts. A new request is accepted only after `wake_req` has been low.
- R6: Dropping `wake_req` during the idle wait abandons the sequence with no drive.
- R7: Both interrupt flags stay set until a 1 is written on their clear input. When a set and a clear fall on the same edge, the flag ends up set.
- R8: A rising edge of `osc_pwr_down` while the oscillator is ready turns `osc_en` off on that clock edge.
- R9: With the oscillator off and `host_wake_en`=1, a falling edge on D+ (1 on one edge, 0 on the next) restarts the oscillator on the edge that sees the 0. With `host_wake_en`=0, the edge is ignored and the oscillator stays off.
- R10: With the oscillator off, a low `osc_pwr_down` also restarts it.
- R11: After a restart, `osc_en` is 1 and `osc_stable` is 0 for OSC_STABLE_TICKS tick edges. On the last of those edges, `osc_stable` rises and `osc_ready_irq` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_12m | input | 1 | One-cycle pulse at the 12 MHz rate |
| line_dp | input | 1 | Synchronised D+ line level |
| line_dm | input | 1 | Synchronised D- line level |
| wake_req | input | 1 | Firmware request for device-initiated resume |
| host_wake_en | input | 1 | Allow D+ falling edge to restart the oscillator |
| osc_pwr_down | input | 1 | Firmware oscillator stop control |
| clr_rwu_done | input | 1 | Write-1 clear of the resume-done flag |
| clr_osc_ready | input | 1 | Write-1 clear of the oscillator-ready flag |
| resume_drive_en | output | 1 | Transceiver drive enable during resume |
| drv_dp | output | 1 | Driven D+ level |
| drv_dm | output | 1 | Driven D- level |
| osc_en | output | 1 | Oscillator enable |
| osc_stable | output | 1 | Oscillator has finished its stabilisation wait |
| rwu_done_irq | output | 1 | Sticky resume-done interrupt flag |
| osc_ready_irq | output | 1 | Sticky oscillator-ready interrupt flag |

## Verification
The idle wait is tried with a steady J line, which fixes the exact start edge of the drive, and with a single SE0 glitch partway through, which separates a counter that restarts from one that only pauses. Random stretches of sparse ticks, with short K, SE0 and SE1 bursts, show whether gaps in the tick are treated differently from line disturbances. Requests that are held, dropped early and re-raised separate the abort path from the done path that waits for firmware. On the oscillator side, D+ falls with the wake enable both on and off tell a gated restart from an ungated one. Power-down pulses and random clear strobes that land on set edges exercise the restart that comes from power-down release and the case where a set wins over a clear.

// File: rtl/usb_wake_pkg.sv
package usb_wake_pkg;

    typedef enum logic [1:0] {
        DEV_IDLE,
        DEV_WAIT_IDLE,
        DEV_DRIVE_RESUME,
        DEV_DONE
    } dev_state_e;

    typedef enum logic [1:0] {
        OSC_OFF,
        OSC_START,
        OSC_READY
    } osc_state_e;

    typedef struct packed {
        logic dp;
        logic dm;
    } line_t;

    localparam line_t LINE_K     = '{dp: 1'b0, dm: 1'b1};
    localparam line_t LINE_QUIET = '{dp: 1'b0, dm: 1'b0};

    localparam int unsigned NUM_IRQ = 2;
    localparam int unsigned IRQ_RWU = 0;
    localparam int unsigned IRQ_OSC = 1;

    function automatic logic line_is_j(line_t l);
        return l.dp & ~l.dm;
    endfunction

    // bits needed for a counter running 0 .. n-1
    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/usb_wake_line_mon.sv
module usb_wake_line_mon
    import usb_wake_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  line_dp,
    input  logic  line_dm,
    output line_t line_now,
    output logic  j_state,
    output logic  dp_fall
);
    logic dp_q;

    always_ff @(posedge clk) begin
        if (rst) dp_q <= 1'b0;
        else     dp_q <= line_dp;
    end

    assign line_now = '{dp: line_dp, dm: line_dm};
    assign j_state  = line_is_j(line_now);
    assign dp_fall  = dp_q & ~line_dp;
endmodule

// File: rtl/usb_wake_dev_fsm.sv
module usb_wake_dev_fsm
    import usb_wake_pkg::*;
#(
    parameter int unsigned IDLE_TICKS   = 60000,
    parameter int unsigned RESUME_TICKS = 120000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic wake_req,
    input  logic j_state,
    output logic drive_en,
    output logic done_set
);
    localparam int unsigned MAX_T = (IDLE_TICKS > RESUME_TICKS) ? IDLE_TICKS : RESUME_TICKS;
    localparam int unsigned CW    = cnt_width(MAX_T);
    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_TICKS - 1);
    localparam logic [CW-1:0] RES_LAST  = CW'(RESUME_TICKS - 1);

    dev_state_e    st, st_n;
    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        done_set = 1'b0;
        unique case (st)
            DEV_IDLE: begin
                if (wake_req) begin
                    st_n  = DEV_WAIT_IDLE;
                    cnt_n = '0;
                end
            end
            DEV_WAIT_IDLE: begin
                if (!wake_req) begin
                    st_n = DEV_IDLE;
                end else if (!j_state) begin
                    cnt_n = '0;
                end else if (tick) begin
                    if (cnt == IDLE_LAST) begin
                        st_n  = DEV_DRIVE_RESUME;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            DEV_DRIVE_RESUME: begin
                if (tick) begin
                    if (cnt == RES_LAST) begin
                        st_n     = DEV_DONE;
                        cnt_n    = '0;
                        done_set = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            DEV_DONE: begin
                if (!wake_req) st_n = DEV_IDLE;
            end
            default: st_n = DEV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= DEV_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    assign drive_en = (st == DEV_DRIVE_RESUME);
endmodule

// File: rtl/usb_wake_osc_fsm.sv
module usb_wake_osc_fsm
    import usb_wake_pkg::*;
#(
    parameter int unsigned STABLE_TICKS = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic host_wake_en,
    input  logic dp_fall,
    input  logic pwr_down,
    output logic osc_en,
    output logic osc_stable,
    output logic ready_set
);
    localparam int unsigned CW = cnt_width(STABLE_TICKS);
    localparam logic [CW-1:0] STB_LAST = CW'(STABLE_TICKS - 1);

    osc_state_e    st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          pd_q;
    logic          pd_rise;

    assign pd_rise = pwr_down & ~pd_q;

    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        ready_set = 1'b0;
        unique case (st)
            OSC_READY: begin
                if (pd_rise) st_n = OSC_OFF;
            end
            OSC_OFF: begin
                if ((host_wake_en && dp_fall) || !pwr_down) begin
                    st_n  = OSC_START;
                    cnt_n = '0;
                end
            end
            OSC_START: begin
                if (tick) begin
                    if (cnt == STB_LAST) begin
                        st_n      = OSC_READY;
                        cnt_n     = '0;
                        ready_set = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            default: st_n = OSC_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= OSC_READY;
            cnt  <= '0;
            pd_q <= 1'b0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            pd_q <= pwr_down;
        end
    end

    assign osc_en     = (st != OSC_OFF);
    assign osc_stable = (st == OSC_READY);
endmodule

// File: rtl/usb_wake_irq_bank.sv
module usb_wake_irq_bank #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flag[i] <= 1'b0;
            else     flag[i] <= set[i] | (flag[i] & ~clr[i]);
        end
    end
endmodule

// File: rtl/usb_wake_seq.sv
module usb_wake_seq
    import usb_wake_pkg::*;
#(
    parameter int unsigned IDLE_TICKS       = 60000,
    parameter int unsigned RESUME_TICKS     = 120000,
    parameter int unsigned OSC_STABLE_TICKS = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_12m,
    input  logic line_dp,
    input  logic line_dm,
    input  logic wake_req,
    input  logic host_wake_en,
    input  logic osc_pwr_down,
    input  logic clr_rwu_done,
    input  logic clr_osc_ready,
    output logic resume_drive_en,
    output logic drv_dp,
    output logic drv_dm,
    output logic osc_en,
    output logic osc_stable,
    output logic rwu_done_irq,
    output logic osc_ready_irq
);
    line_t              line_now;
    line_t              drv;
    logic               j_state;
    logic               dp_fall;
    logic               done_set;
    logic               ready_set;
    logic [NUM_IRQ-1:0] irq_set;
    logic [NUM_IRQ-1:0] irq_clr;
    logic [NUM_IRQ-1:0] irq_flag;

    usb_wake_line_mon u_line (
        .clk      (clk),
        .rst      (rst),
        .line_dp  (line_dp),
        .line_dm  (line_dm),
        .line_now (line_now),
        .j_state  (j_state),
        .dp_fall  (dp_fall)
    );

    usb_wake_dev_fsm #(
        .IDLE_TICKS   (IDLE_TICKS),
        .RESUME_TICKS (RESUME_TICKS)
    ) u_dev (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_12m),
        .wake_req (wake_req),
        .j_state  (j_state),
        .drive_en (resume_drive_en),
        .done_set (done_set)
    );

    usb_wake_osc_fsm #(
        .STABLE_TICKS (OSC_STABLE_TICKS)
    ) u_osc (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick_12m),
        .host_wake_en (host_wake_en),
        .dp_fall      (dp_fall),
        .pwr_down     (osc_pwr_down),
        .osc_en       (osc_en),
        .osc_stable   (osc_stable),
        .ready_set    (ready_set)
    );

    always_comb begin
        irq_set          = '0;
        irq_clr          = '0;
        irq_set[IRQ_RWU] = done_set;
        irq_set[IRQ_OSC] = ready_set;
        irq_clr[IRQ_RWU] = clr_rwu_done;
        irq_clr[IRQ_OSC] = clr_osc_ready;
    end

    usb_wake_irq_bank #(
        .N (NUM_IRQ)
    ) u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (irq_set),
        .clr  (irq_clr),
        .flag (irq_flag)
    );

    assign drv           = resume_drive_en ? LINE_K : LINE_QUIET;
    assign drv_dp        = drv.dp;
    assign drv_dm        = drv.dm;
    assign rwu_done_irq  = irq_flag[IRQ_RWU];
    assign osc_ready_irq = irq_flag[IRQ_OSC];
endmodule

// File: rtl/usb_wake_seq_chk.sv
module usb_wake_seq_chk (
    input logic clk,
    input logic rst,
    input logic line_dp,
    input logic line_dm,
    input logic wake_req,
    input logic clr_rwu_done,
    input logic clr_osc_ready,
    input logic resume_drive_en,
    input logic drv_dp,
    input logic drv_dm,
    input logic osc_en,
    input logic osc_stable,
    input logic rwu_done_irq,
    input logic osc_ready_irq
);
    // R4: K on the line whenever driving, quiet otherwise
    a_r4_k_state: assert property (@(posedge clk) disable iff (rst)
        resume_drive_en |-> (!drv_dp && drv_dm));
    a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
        !resume_drive_en |-> (!drv_dp && !drv_dm));
    // R2: drive starts only after a request and a J sample
    a_r2_start_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(resume_drive_en) |-> $past(wake_req));
    a_r2_start_needs_j: assert property (@(posedge clk) disable iff (rst)
        $rose(resume_drive_en) |-> $past(line_dp && !line_dm));
    // R5: end of drive raises the done flag
    a_r5_done_flag: assert property (@(posedge clk) disable iff (rst)
        $fell(resume_drive_en) |-> rwu_done_irq);
    // R7: flags are sticky until cleared
    a_r7_rwu_sticky: assert property (@(posedge clk) disable iff (rst)
        (rwu_done_irq && !clr_rwu_done) |=> rwu_done_irq);
    a_r7_osc_sticky: assert property (@(posedge clk) disable iff (rst)
        (osc_ready_irq && !clr_osc_ready) |=> osc_ready_irq);
    // R11: stable implies running; becoming stable raises the ready flag
    a_r11_stable_running: assert property (@(posedge clk) disable iff (rst)
        osc_stable |-> osc_en);
    a_r11_ready_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_stable) |-> osc_ready_irq);
endmodule

bind usb_wake_seq usb_wake_seq_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .line_dp         (line_dp),
    .line_dm         (line_dm),
    .wake_req        (wake_req),
    .clr_rwu_done    (clr_rwu_done),
    .clr_osc_ready   (clr_osc_ready),
    .resume_drive_en (resume_drive_en),
    .drv_dp          (drv_dp),
    .drv_dm          (drv_dm),
    .osc_en          (osc_en),
    .osc_stable      (osc_stable),
    .rwu_done_irq    (rwu_done_irq),
    .osc_ready_irq   (osc_ready_irq)
);

// File: tb/tb_usb_wake_seq.sv
module tb_usb_wake_seq;
    localparam int IDLE_T = 12;
    localparam int RES_T  = 9;
    localparam int OSC_T  = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_12m = 1'b1, line_dp = 1'b1, line_dm = 1'b0, wake_req = 1'b0;
    logic host_wake_en = 1'b0, osc_pwr_down = 1'b0, clr_rwu_done = 1'b0, clr_osc_ready = 1'b0;
    logic resume_drive_en, drv_dp, drv_dm, osc_en, osc_stable, rwu_done_irq, osc_ready_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    usb_wake_seq #(.IDLE_TICKS(IDLE_T), .RESUME_TICKS(RES_T), .OSC_STABLE_TICKS(OSC_T)) dut (
        .clk(clk), .rst(rst), .tick_12m(tick_12m), .line_dp(line_dp), .line_dm(line_dm),
        .wake_req(wake_req), .host_wake_en(host_wake_en), .osc_pwr_down(osc_pwr_down),
        .clr_rwu_done(clr_rwu_done), .clr_osc_ready(clr_osc_ready),
        .resume_drive_en(resume_drive_en), .drv_dp(drv_dp), .drv_dm(drv_dm),
        .osc_en(osc_en), .osc_stable(osc_stable), .rwu_done_irq(rwu_done_irq),
        .osc_ready_irq(osc_ready_irq));

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference behaviour from the requirements, advanced per clock edge.
    // dev: 0 idle, 1 wait, 2 drive, 3 done; osc: 0 off, 1 start, 2 ready
    int   m_dev, m_dcnt, m_osc, m_ocnt;
    logic m_dpq, m_pdq, m_rwu, m_oirq;

    function automatic logic exp_drive(int dev);
        return dev == 2;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_dev = 0; m_dcnt = 0; m_osc = 2; m_ocnt = 0;
            m_dpq = 0; m_pdq = 0; m_rwu = 0; m_oirq = 0;
        end else begin
            automatic logic j    = line_dp && !line_dm;
            automatic logic fall = m_dpq && !line_dp;
            automatic logic pdr  = osc_pwr_down && !m_pdq;
            automatic logic rs   = 1'b0;
            automatic logic os   = 1'b0;
            case (m_dev)
                0: if (wake_req) begin m_dev = 1; m_dcnt = 0; end
                1: if (!wake_req) m_dev = 0;
                   else if (!j) m_dcnt = 0;
                   else if (tick_12m) begin
                       if (m_dcnt == IDLE_T - 1) begin m_dev = 2; m_dcnt = 0; end
                       else m_dcnt++;
                   end
                2: if (tick_12m) begin
                       if (m_dcnt == RES_T - 1) begin m_dev = 3; m_dcnt = 0; rs = 1; end
                       else m_dcnt++;
                   end
                default: if (!wake_req) m_dev = 0;
            endcase
            case (m_osc)
                2: if (pdr) m_osc = 0;
                0: if ((host_wake_en && fall) || !osc_pwr_down) begin m_osc = 1; m_ocnt = 0; end
                default: if (tick_12m) begin
                       if (m_ocnt == OSC_T - 1) begin m_osc = 2; m_ocnt = 0; os = 1; end
                       else m_ocnt++;
                   end
            endcase
            m_rwu  = rs | (m_rwu & !clr_rwu_done);
            m_oirq = os | (m_oirq & !clr_osc_ready);
            m_dpq  = line_dp;
            m_pdq  = osc_pwr_down;
        end
    end

    // continuous comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R2 drive_en model", resume_drive_en, exp_drive(m_dev));
            check("R4 drv_dp model", drv_dp, 1'b0);
            check("R4 drv_dm model", drv_dm, exp_drive(m_dev));
            check("R5 rwu_done_irq model", rwu_done_irq, m_rwu);
            check("R8 osc_en model", osc_en, m_osc != 0);
            check("R11 osc_stable model", osc_stable, m_osc == 2);
            check("R7 osc_ready_irq model", osc_ready_irq, m_oirq);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_line(input logic dp, input logic dm);
        line_dp = dp; line_dm = dm;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc(1);
        // R1: reset state
        check("R1 drive off", resume_drive_en, 1'b0);
        check("R1 drv_dm quiet", drv_dm, 1'b0);
        check("R1 osc_en", osc_en, 1'b1);
        check("R1 osc_stable", osc_stable, 1'b1);
        check("R1 rwu irq", rwu_done_irq, 1'b0);
        check("R1 osc irq", osc_ready_irq, 1'b0);

        // R2: steady J, tick every cycle
        wake_req = 1'b1;
        for (int k = 1; k <= IDLE_T; k++) begin
            cyc(1);
            check("R2 no drive during idle wait", resume_drive_en, 1'b0);
        end
        cyc(1);
        check("R2 drive starts", resume_drive_en, 1'b1);
        // R4: drive length and K state
        for (int k = 1; k < RES_T; k++) begin
            cyc(1);
            check("R4 drive held", resume_drive_en, 1'b1);
            check("R4 K on D-", drv_dm, 1'b1);
        end
        cyc(1);
        check("R4 drive ends", resume_drive_en, 1'b0);
        check("R5 done flag set", rwu_done_irq, 1'b1);
        // R5: request held high, no restart
        for (int k = 0; k < IDLE_T + 5; k++) begin
            cyc(1);
            check("R5 no second drive while held", resume_drive_en, 1'b0);
        end
        // R7: clear
        clr_rwu_done = 1'b1;
        cyc(1);
        clr_rwu_done = 1'b0;
        check("R7 rwu flag cleared", rwu_done_irq, 1'b0);
        wake_req = 1'b0;
        cyc(2);

        // R3: SE0 glitch restarts the count
        wake_req = 1'b1;
        cyc(IDLE_T - 1);
        check("R3 no drive before glitch", resume_drive_en, 1'b0);
        set_line(1'b0, 1'b0);
        cyc(1);
        set_line(1'b1, 1'b0);
        for (int k = 1; k < IDLE_T; k++) begin
            cyc(1);
            check("R3 count restarted", resume_drive_en, 1'b0);
        end
        cyc(1);
        check("R3 drive after full idle", resume_drive_en, 1'b1);
        cyc(RES_T + 1);
        wake_req = 1'b0;
        clr_rwu_done = 1'b1;
        cyc(1);
        clr_rwu_done = 1'b0;

        // R6: abort during wait
        wake_req = 1'b1;
        cyc(3);
        wake_req = 1'b0;
        for (int k = 0; k < IDLE_T + 4; k++) begin
            cyc(1);
            check("R6 aborted, no drive", resume_drive_en, 1'b0);
        end

        // R8: power down
        osc_pwr_down = 1'b1;
        cyc(1);
        check("R8 oscillator off", osc_en, 1'b0);
        // R9: fall ignored without enable
        set_line(1'b0, 1'b1);
        cyc(1);
        cyc(1);
        check("R9 fall ignored", osc_en, 1'b0);
        set_line(1'b1, 1'b0);
        cyc(2);
        host_wake_en = 1'b1;
        set_line(1'b0, 1'b1);
        cyc(1);
        check("R9 restart on fall", osc_en, 1'b1);
        check("R11 not yet stable", osc_stable, 1'b0);
        for (int k = 1; k < OSC_T; k++) begin
            cyc(1);
            check("R11 still settling", osc_stable, 1'b0);
        end
        cyc(1);
        check("R11 stable", osc_stable, 1'b1);
        check("R11 ready flag", osc_ready_irq, 1'b1);
        set_line(1'b1, 1'b0);
        host_wake_en = 1'b0;
        osc_pwr_down = 1'b0;
        clr_osc_ready = 1'b1;
        cyc(1);
        clr_osc_ready = 1'b0;
        check("R7 osc flag cleared", osc_ready_irq, 1'b0);
        // R10: power-down release restarts
        osc_pwr_down = 1'b1;
        cyc(1);
        osc_pwr_down = 1'b0;
        cyc(1);
        check("R10 restart on release", osc_en, 1'b1);
        check("R10 settling", osc_stable, 1'b0);
        cyc(OSC_T + 2);

        // random phase: compared each cycle against the reference
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            tick_12m = ($urandom % 4) != 0;
            if (($urandom % 12) == 0) set_line(1'($urandom), 1'($urandom));
            else if (($urandom % 3) == 0) set_line(1'b1, 1'b0);
            if (($urandom % 70) == 0) wake_req = ~wake_req;
            if (($urandom % 40) == 0) host_wake_en = ~host_wake_en;
            if (($urandom % 90) == 0) osc_pwr_down = ~osc_pwr_down;
            clr_rwu_done  = ($urandom % 8) == 0;
            clr_osc_ready = ($urandom % 8) == 0;
        end
        cyc(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule